// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

The block arbitrates eight synchronous, level-sensitive request lines on behalf of a processor. Each request is caught in a pending latch and filtered by a per-line mask. The block picks the best eligible line and raises a single interrupt output. When the processor acknowledges, the block presents the 3-bit index of the winning line, marks that line as in service and drops its pending latch. The in-service record gives nesting: a new request interrupts only when it outranks every line already being serviced.

A small write port holds a control word, the mask and an end-of-interrupt command. The control word chooses between two priority schemes. In fixed order, line 0 is the best and line 7 the worst. In rotating order, the line most recently retired by an end-of-interrupt becomes the worst, and the ranking wraps around from the line after it. A second control bit enables a selective-mask mode. In that mode a masked line that is in service stops blocking lower-ranked lines, so the processor can let them through while it is still handling the masked one.

A two-state machine sequences the interrupt. **ST_IDLE** waits for an eligible winner; the transition *arm* (an eligible winner exists) goes to **ST_REQ**. **ST_REQ** drives the interrupt. The transition *take* (acknowledge while the interrupt is high) and the transition *withdraw* (no eligible winner any more) both return to ST_IDLE.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A line whose `req_i` bit is high at a rising clock edge becomes pending and stays pending after `req_i` falls, until that line is acknowledged.
- R2: When a request is first sampled at edge k and is eligible, `irq_o` is low until edge k+1 and high after edge k+1 (ST_IDLE to ST_REQ via *arm*).
- R3: A write to address 1 loads the mask from `wr_data_i`; a set bit i keeps line i from raising `irq_o` while its pending latch is kept; clearing the bit lets the held request through.
- R4: In fixed order a lower index beats a higher one, and a pending line raises `irq_o` only when its rank is strictly better than that of every in-service line.
- R5: An `ack_i` sampled while `irq_o` is high loads `vec_o` with the winner's index after that edge, sets its in-service bit, clears its pending latch and drops `irq_o`. An `ack_i` sampled while `irq_o` is low changes nothing, and `vec_o` changes only on an accepted acknowledge.
- R6: A write to address 2 (end of interrupt) clears the best-ranked in-service bit under the current order; with nothing in service it has no effect.
- R7: In rotating order, an end of interrupt that clears line i makes line i the lowest rank and line (i+1) mod 8 the highest.
- R8: With selective-mask mode on, an in-service line whose mask bit is set does not block lower-ranked requests.
- R9: Reset (active-low `rst_n`) clears the pending, in-service and mask registers, clears `vec_o`, selects fixed order with selective mask off, and holds `irq_o` low.
- R10: A write to address 0 loads the control word: bit 0 set selects rotating order, bit 1 set enables selective mask. Writes to address 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Level-sensitive request lines, bit i is line i |
| ack_i | input | 1 | Processor acknowledge pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 control, 1 mask, 2 end of interrupt, 3 unused |
| wr_data_i | input | 8 | Write data |
| irq_o | output | 1 | Interrupt to the processor |
| vec_o | output | 3 | Index of the last acknowledged line |

## Verification
The bench builds the block with its default of eight lines, which gives a 3-bit vector and a full wrap of the rotating order. With that width, walking the rotating pointer all the way round and back to line 0 takes only a few dozen cycles. The eight lines also allow two- and three-deep nesting of in-service lines. Keeping the line count at a power of two means the wrap-around rank arithmetic is exercised by its natural overflow.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } irq_state_t;

    localparam logic [1:0] WA_CTRL = 2'd0;
    localparam logic [1:0] WA_MASK = 2'd1;
    localparam logic [1:0] WA_EOI  = 2'd2;
endpackage

// File: rtl/irq_rank_pick.sv
module irq_rank_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N),
    parameter int RW = IW + 1
) (
    input  logic [N-1:0]  vec_i,
    input  logic [IW-1:0] base_i,
    output logic [IW-1:0] idx_o,
    output logic [RW-1:0] rank_o
);
    logic [IW-1:0] pos_a [N];
    logic [N-1:0]  rot_v;

    for (genvar g = 0; g < N; g++) begin : g_rot
        assign pos_a[g] = base_i + IW'(g + 1);
        assign rot_v[g] = vec_i[pos_a[g]];
    end

    always_comb begin
        idx_o  = '0;
        rank_o = RW'(N);
        for (int k = N - 1; k >= 0; k--) begin
            if (rot_v[k]) begin
                idx_o  = pos_a[k];
                rank_o = RW'(k);
            end
        end
    end
endmodule

// File: rtl/irq_ctrl_fsm.sv
module irq_ctrl_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic grant_ok_i,
    input  logic ack_i,
    output logic irq_o,
    output logic take_o
);
    irq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        irq_o   = 1'b0;
        take_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (grant_ok_i) state_d = ST_REQ;
            end
            ST_REQ: begin
                irq_o  = grant_ok_i;
                take_o = grant_ok_i && ack_i;
                if (!grant_ok_i || ack_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assert_ack_drops_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !irq_o);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !$past(irq_o));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic          ack_i,
    input  logic          wr_en_i,
    input  logic [1:0]    wr_addr_i,
    input  logic [N-1:0]  wr_data_i,
    output logic          irq_o,
    output logic [IW-1:0] vec_o
);
    localparam int RW = IW + 1;
    localparam logic [IW-1:0] FIXED_BASE = IW'(N - 1);

    logic [N-1:0]  pend_q, isr_q, mask_q;
    logic          rot_q, smm_q;
    logic [IW-1:0] bp_q, vec_q;

    logic [IW-1:0] base_eff, req_idx, blk_idx, eoi_idx;
    logic [RW-1:0] req_rank, blk_rank, eoi_rank;
    logic [N-1:0]  blk_view, win_oh, eoi_oh;
    logic          grant_ok, take, eoi_cmd, eoi_hit;

    assign base_eff = rot_q ? bp_q : FIXED_BASE;
    assign blk_view = smm_q ? (isr_q & ~mask_q) : isr_q;

    irq_rank_pick #(.N(N), .IW(IW), .RW(RW)) u_pick_req (
        .vec_i(pend_q & ~mask_q), .base_i(base_eff), .idx_o(req_idx), .rank_o(req_rank));
    irq_rank_pick #(.N(N), .IW(IW), .RW(RW)) u_pick_blk (
        .vec_i(blk_view), .base_i(base_eff), .idx_o(blk_idx), .rank_o(blk_rank));
    irq_rank_pick #(.N(N), .IW(IW), .RW(RW)) u_pick_eoi (
        .vec_i(isr_q), .base_i(base_eff), .idx_o(eoi_idx), .rank_o(eoi_rank));

    assign grant_ok = req_rank < blk_rank;

    irq_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .grant_ok_i(grant_ok), .ack_i(ack_i),
        .irq_o(irq_o), .take_o(take));

    assign eoi_cmd = wr_en_i && (wr_addr_i == WA_EOI);
    assign eoi_hit = eoi_cmd && (eoi_rank != RW'(N));
    assign win_oh  = take    ? (N'(1) << req_idx) : '0;
    assign eoi_oh  = eoi_hit ? (N'(1) << eoi_idx) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            isr_q  <= '0;
            mask_q <= '0;
            rot_q  <= 1'b0;
            smm_q  <= 1'b0;
            bp_q   <= FIXED_BASE;
            vec_q  <= '0;
        end else begin
            pend_q <= (pend_q | req_i) & ~win_oh;
            isr_q  <= (isr_q & ~eoi_oh) | win_oh;
            if (take) vec_q <= req_idx;
            if (eoi_hit && rot_q) bp_q <= eoi_idx;
            if (wr_en_i && wr_addr_i == WA_CTRL) begin
                rot_q <= wr_data_i[0];
                smm_q <= wr_data_i[1];
            end
            if (wr_en_i && wr_addr_i == WA_MASK) mask_q <= wr_data_i;
        end
    end

    assign vec_o = vec_q;

    assert_vec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_i && irq_o) |=> $stable(vec_o));
    assert_isr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> isr_q[vec_o]);
    assert_mask_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !mask_q[req_idx]);
    assert_nest_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !isr_q[req_idx]);
    assert_smm_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && (blk_rank != RW'(N))) |-> (smm_q ? !mask_q[blk_idx] : 1'b1));
    assert_eoi_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_cmd && isr_q == '0 && !take) |=> (isr_q == '0));
    assert_rotate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_hit && rot_q) |=> (bp_q == $past(eoi_idx)));
    assert_reset_R9: assert property (@(posedge clk)
        !rst_n |=> (isr_q == '0 && mask_q == '0 && pend_q == '0 && !rot_q && !irq_o));
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_i = '0;
    logic       ack_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic       irq_o;
    logic [2:0] vec_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    string phase = "R9";

    prio_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .irq_o(irq_o), .vec_o(vec_o));

    always #(CLK_PERIOD / 2) clk = ~clk;

    // behavioural reference state
    bit m_pend[8], m_isr[8], m_mask[8];
    bit m_rot, m_smm, m_req_st;
    int m_bp, m_vec;

    function automatic int eff_base();
        return m_rot ? m_bp : 7;
    endfunction

    function automatic void winner(output int w, output bit ok);
        int wr = 8, br = 8;
        w = 0;
        for (int k = 7; k >= 0; k--) begin
            int p = (eff_base() + 1 + k) % 8;
            if (m_pend[p] && !m_mask[p]) begin wr = k; w = p; end
            if (m_isr[p] && !(m_smm && m_mask[p])) br = k;
        end
        ok = wr < br;
    endfunction

    function automatic int eoi_target();
        for (int k = 0; k < 8; k++) begin
            int p = (eff_base() + 1 + k) % 8;
            if (m_isr[p]) return p;
        end
        return -1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin m_pend[i] = 0; m_isr[i] = 0; m_mask[i] = 0; end
            m_rot = 0; m_smm = 0; m_req_st = 0; m_bp = 7; m_vec = 0;
        end else begin
            int w, t;
            bit ok, took;
            winner(w, ok);
            t = eoi_target();
            took = m_req_st && ok && ack_i;
            for (int i = 0; i < 8; i++) if (req_i[i]) m_pend[i] = 1;
            if (wr_en_i && wr_addr_i == 2'd2 && t >= 0) begin
                m_isr[t] = 0;
                if (m_rot) m_bp = t;
            end
            if (took) begin m_pend[w] = 0; m_isr[w] = 1; m_vec = w; end
            if (m_req_st) m_req_st = ok && !ack_i;
            else          m_req_st = ok;
            if (wr_en_i && wr_addr_i == 2'd0) begin m_rot = wr_data_i[0]; m_smm = wr_data_i[1]; end
            if (wr_en_i && wr_addr_i == 2'd1)
                for (int i = 0; i < 8; i++) m_mask[i] = wr_data_i[i];
        end
    end

    task automatic check(string tag, int act, int exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int w;
            bit ok;
            winner(w, ok);
            check(phase, irq_o, m_req_st && ok, "irq_o vs model");
            check(phase, vec_o, m_vec, "vec_o vs model");
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic pulse_req(logic [7:0] v);
        req_i = v; tick(1); req_i = '0;
    endtask
    task automatic do_ack();
        ack_i = 1'b1; tick(1); ack_i = 1'b0;
    endtask
    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; tick(1); wr_en_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        check("R9", irq_o, 0, "irq in reset");
        check("R9", vec_o, 0, "vec in reset");
        rst_n = 1'b1;
        tick(2);

        phase = "R1";
        req_i = 8'h20; tick(1); req_i = '0;
        check("R2", irq_o, 0, "irq one cycle after sample");
        tick(1);
        check("R1", irq_o, 1, "irq after request fell");
        phase = "R5";
        do_ack();
        check("R5", vec_o, 5, "vector after ack");
        check("R5", irq_o, 0, "irq after ack");

        phase = "R4";
        pulse_req(8'h48);
        tick(1);
        check("R4", irq_o, 1, "line3 outranks in-service 5");
        do_ack();
        check("R4", vec_o, 3, "lower index wins");
        tick(2);
        check("R4", irq_o, 0, "line6 blocked by service");
        wr(2'd2, '0);
        tick(2);
        check("R6", irq_o, 0, "eoi cleared 3, 5 still blocks");
        wr(2'd2, '0);
        tick(1);
        check("R6", irq_o, 1, "eoi cleared 5, line6 released");
        do_ack();
        check("R4", vec_o, 6, "held line6 served");
        wr(2'd2, '0);

        phase = "R6";
        wr(2'd2, '0);
        tick(2);
        check("R6", irq_o, 0, "eoi with empty service");
        phase = "R5";
        do_ack();
        check("R5", vec_o, 6, "ack while idle ignored");

        phase = "R3";
        wr(2'd1, 8'h04);
        pulse_req(8'h04);
        tick(2);
        check("R3", irq_o, 0, "masked line silent");
        wr(2'd1, 8'h00);
        tick(1);
        check("R3", irq_o, 1, "unmasked line fires");
        do_ack();
        check("R3", vec_o, 2, "held masked request served");
        wr(2'd2, '0);

        phase = "R8";
        pulse_req(8'h02);
        tick(1);
        do_ack();
        check("R8", vec_o, 1, "line1 in service");
        wr(2'd1, 8'h02);
        pulse_req(8'h10);
        tick(2);
        check("R8", irq_o, 0, "masked service still blocks without mode");
        wr(2'd0, 8'h02);
        tick(1);
        check("R8", irq_o, 1, "selective mask releases line4");
        do_ack();
        check("R8", vec_o, 4, "line4 served");
        wr(2'd2, '0);
        wr(2'd2, '0);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);

        phase = "R7";
        wr(2'd0, 8'h01);
        wr(2'd3, 8'hFF);
        pulse_req(8'hFF);
        tick(1);
        do_ack();
        check("R10", vec_o, 0, "rotating starts at line0");
        wr(2'd2, '0);
        pulse_req(8'h01);
        do_ack();
        check("R7", vec_o, 1, "line0 dropped to lowest");
        wr(2'd2, '0);
        for (int i = 2; i < 9; i++) begin
            tick(1);
            check("R7", irq_o, 1, "rotating irq");
            do_ack();
            check("R7", vec_o, i % 8, "rotating order");
            wr(2'd2, '0);
        end
        wr(2'd0, 8'h00);
        tick(3);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule